// File: doc/BRIEF.md
# Cache-Line Split Unit

This unit sits between a load/store stage and a single data-cache request port. It accepts one access of 1 to `MAX_BYTES` bytes at a time. If the bytes of the access span two cache lines, it turns the access into two sub-requests, each held inside one line. It issues them one after the other, never both at once. Read bytes that come back are gathered into one result word, and the unit reports completion once every half has answered.

The cache port may refuse a sub-request. When it does, the unit holds back until the cache signals a retry, and then presents the same sub-request again. A split write that is marked atomic (swap, compare-swap or store-conditional) is never issued. It is reported straight away as a failed completion.

Top module: `line_split_unit`

## Requirements
- R1: For an accepted access of `size` bytes at `addr`, the boundary is `bnd = floor((addr+size-1)/LINE_BYTES)*LINE_BYTES`, and the access is split only when `bnd > addr`. An access that is not split goes out as one sub-request with the original address and size.
- R2: A split access issues its first half at `addr` with size `bnd-addr`, and its second half at `bnd` with size `addr+size-bnd`. The second half is presented only after the first half's response has arrived.
- R3: For a write half that begins at byte offset `off` within the access (0 or `bnd-addr`), `c_req_wdata` byte j equals `req_wdata` byte `off+j`, and `c_req_be` bit j is set, for every j below the half's size. All other bytes and enables are zero, and a read drives zero wdata and zero enables.
- R4: Response bytes 0 to size-1 of the first half land in `done_data` bytes starting at offset 0. Those of the second half land starting at offset `bnd-addr`. Response bytes above the half's size are dropped, and `done_data` bytes not written, and the whole of `done_data` for a write, read as zero.
- R5: `done_valid` pulses for exactly one cycle, in the cycle after the clock edge that samples the final response: the second one for a split access, the only one otherwise. A first-half response alone never raises it.
- R6: A cycle in which `c_req_valid` is high and `c_req_accept` is low blocks the port. From the next cycle on, `c_req_valid` stays low until a retry arrives, and no response is expected for the refused sub-request.
- R7: `c_retry` high while blocked unblocks the port. In the next cycle the refused sub-request is presented again, with unchanged address, size, data and enables.
- R8: An access with `req_write=1` and `req_atomic=1` that R1 would split is not issued. In the next cycle `done_valid=1` and `done_error=1` with `done_data` zero. An atomic access that is not split, or an atomic split read, proceeds normally with `done_error=0`.
- R9: After reset `req_ready=1`, `c_req_valid=0` and `done_valid=0`.
- R10: `req_ready` is high only while no access is in flight. A `req_valid` seen while `req_ready` is low is ignored and does not change the sub-requests or result of the access in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Unit idle and able to take an access |
| req_addr | input | AW | Byte address of the access |
| req_size | input | SZW | Byte count, 1..MAX_BYTES |
| req_write | input | 1 | 1 = write, 0 = read |
| req_atomic | input | 1 | Access is swap, compare-swap or store-conditional |
| req_wdata | input | DW | Write bytes, byte 0 at address `req_addr` |
| c_req_valid | output | 1 | Sub-request presented to the cache |
| c_req_accept | input | 1 | Cache takes the presented sub-request |
| c_req_addr | output | AW | Sub-request address |
| c_req_size | output | SZW | Sub-request byte count |
| c_req_write | output | 1 | Sub-request is a write |
| c_req_wdata | output | DW | Sub-request write bytes, lane 0 first |
| c_req_be | output | MAX_BYTES | Sub-request byte enables |
| c_retry | input | 1 | Cache can take a refused sub-request again |
| c_resp_valid | input | 1 | Response for the outstanding sub-request |
| c_resp_data | input | DW | Response bytes, lane 0 first |
| done_valid | output | 1 | One-cycle completion pulse |
| done_error | output | 1 | Completion is the atomic split-write error |
| done_data | output | DW | Assembled read bytes |

## Verification
An accepted access shows its first sub-request in the cycle after the accepting edge. The next sub-request, or the completion pulse, follows one cycle after the edge that samples each response. An unblocked port presents again one cycle after the retry edge. The atomic split-write error completes one cycle after acceptance. The bench drives inputs just after each rising edge and compares every output one time unit later against a behavioural model. That model advances its expected values by exactly these per-edge rules, so a result that arrives one cycle early or late counts as a mismatch.

// File: rtl/lsplit_pkg.sv
package lsplit_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } lsplit_state_e;
endpackage

// File: rtl/lsplit_plan.sv
module lsplit_plan #(
  parameter int AW         = 32,
  parameter int LINE_BYTES = 64,
  parameter int SZW        = 4
) (
  input  logic [AW-1:0]  addr,
  input  logic [SZW-1:0] size,
  output logic           split,
  output logic [AW-1:0]  bnd,
  output logic [SZW-1:0] size0,
  output logic [SZW-1:0] size1
);
  function automatic logic [AW-1:0] floor_line(input logic [AW-1:0] a);
    return a & ~(AW'(LINE_BYTES) - AW'(1));
  endfunction

  logic [AW-1:0] last_byte;
  logic [AW-1:0] bnd_w;

  assign last_byte = addr + AW'(size) - AW'(1);
  assign bnd_w     = floor_line(last_byte);
  assign split     = bnd_w > addr;
  assign bnd       = bnd_w;
  assign size0     = split ? SZW'(bnd_w - addr) : size;
  assign size1     = split ? SZW'(addr + AW'(size) - bnd_w) : '0;
endmodule

// File: rtl/lsplit_lanes.sv
module lsplit_lanes #(
  parameter int MAX_BYTES = 8,
  parameter int SZW       = 4
) (
  input  logic                   write,
  input  logic [MAX_BYTES*8-1:0] wdata,
  input  logic [SZW-1:0]         off,
  input  logic [SZW-1:0]         sz,
  output logic [MAX_BYTES*8-1:0] lane_data,
  output logic [MAX_BYTES-1:0]   lane_be
);
  logic [MAX_BYTES*8-1:0] shifted;
  assign shifted = wdata >> {off, 3'b000};

  for (genvar j = 0; j < MAX_BYTES; j++) begin : g_lane
    logic in_half;
    assign in_half             = write && (int'(sz) > j);
    assign lane_be[j]          = in_half;
    assign lane_data[j*8 +: 8] = in_half ? shifted[j*8 +: 8] : 8'h00;
  end
endmodule

// File: rtl/lsplit_merge.sv
module lsplit_merge #(
  parameter int MAX_BYTES = 8,
  parameter int SZW       = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clear,
  input  logic                   load,
  input  logic [SZW-1:0]         off,
  input  logic [SZW-1:0]         sz,
  input  logic [MAX_BYTES*8-1:0] din,
  output logic [MAX_BYTES*8-1:0] dout
);
  logic [MAX_BYTES*8-1:0] placed;
  assign placed = din << {off, 3'b000};

  for (genvar j = 0; j < MAX_BYTES; j++) begin : g_byte
    logic hit;
    assign hit = load && (j >= int'(off)) && (j < int'(off) + int'(sz));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     dout[j*8 +: 8] <= 8'h00;
      else if (clear) dout[j*8 +: 8] <= 8'h00;
      else if (hit)   dout[j*8 +: 8] <= placed[j*8 +: 8];
    end
  end

  // R4: a half written into the buffer never runs past its end
  p_merge_fits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (int'(off) + int'(sz) <= MAX_BYTES));
endmodule

// File: rtl/line_split_unit.sv
module line_split_unit #(
  parameter int AW         = 32,
  parameter int LINE_BYTES = 64,
  parameter int MAX_BYTES  = 8,
  localparam int DW        = MAX_BYTES * 8,
  localparam int SZW       = $clog2(MAX_BYTES + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic [AW-1:0]  req_addr,
  input  logic [SZW-1:0] req_size,
  input  logic           req_write,
  input  logic           req_atomic,
  input  logic [DW-1:0]  req_wdata,
  output logic           c_req_valid,
  input  logic           c_req_accept,
  output logic [AW-1:0]  c_req_addr,
  output logic [SZW-1:0] c_req_size,
  output logic           c_req_write,
  output logic [DW-1:0]  c_req_wdata,
  output logic [MAX_BYTES-1:0] c_req_be,
  input  logic           c_retry,
  input  logic           c_resp_valid,
  input  logic [DW-1:0]  c_resp_data,
  output logic           done_valid,
  output logic           done_error,
  output logic [DW-1:0]  done_data
);
  import lsplit_pkg::*;

  function automatic logic [AW-1:0] line_of(input logic [AW-1:0] a);
    return a & ~(AW'(LINE_BYTES) - AW'(1));
  endfunction

  lsplit_state_e  st_q;
  logic [AW-1:0]  addr_q, bnd_q;
  logic [SZW-1:0] s0_q, s1_q;
  logic           wr_q, split_q, half_q, blocked_q;
  logic [DW-1:0]  wdata_q;
  logic [1:0]     fin_q;
  logic           done_valid_q, done_err_q;

  logic           pl_split;
  logic [AW-1:0]  pl_bnd;
  logic [SZW-1:0] pl_s0, pl_s1;

  lsplit_plan #(.AW(AW), .LINE_BYTES(LINE_BYTES), .SZW(SZW)) u_plan (
    .addr(req_addr), .size(req_size), .split(pl_split),
    .bnd(pl_bnd), .size0(pl_s0), .size1(pl_s1));

  // named events
  logic ev_accept, ev_atomic_err, ev_start, ev_issue, ev_taken, ev_refused;
  logic ev_retry_clear, ev_resp, ev_final;
  logic [1:0] fin_need;

  assign req_ready      = (st_q == ST_IDLE) && !blocked_q;
  assign ev_accept      = req_valid && req_ready;
  assign ev_atomic_err  = ev_accept && pl_split && req_write && req_atomic;
  assign ev_start       = ev_accept && !ev_atomic_err;
  assign ev_issue       = (st_q == ST_ISSUE) && !blocked_q;
  assign ev_taken       = ev_issue && c_req_accept;
  assign ev_refused     = ev_issue && !c_req_accept;
  assign ev_retry_clear = blocked_q && c_retry;
  assign ev_resp        = (st_q == ST_WAIT) && c_resp_valid;
  assign fin_need       = split_q ? 2'd2 : 2'd1;
  assign ev_final       = ev_resp && (fin_q + 2'd1 == fin_need);

  logic [SZW-1:0] cur_off, cur_sz;
  assign cur_off = half_q ? s0_q : '0;
  assign cur_sz  = half_q ? s1_q : s0_q;

  lsplit_lanes #(.MAX_BYTES(MAX_BYTES), .SZW(SZW)) u_lanes (
    .write(wr_q), .wdata(wdata_q), .off(cur_off), .sz(cur_sz),
    .lane_data(c_req_wdata), .lane_be(c_req_be));

  lsplit_merge #(.MAX_BYTES(MAX_BYTES), .SZW(SZW)) u_merge (
    .clk(clk), .rst_n(rst_n), .clear(ev_accept), .load(ev_resp && !wr_q),
    .off(cur_off), .sz(cur_sz), .din(c_resp_data), .dout(done_data));

  assign c_req_valid = ev_issue;
  assign c_req_addr  = half_q ? bnd_q : addr_q;
  assign c_req_size  = cur_sz;
  assign c_req_write = wr_q;
  assign done_valid  = done_valid_q;
  assign done_error  = done_err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;  addr_q <= '0; bnd_q <= '0; s0_q <= '0; s1_q <= '0;
      wr_q <= 1'b0;     split_q <= 1'b0; half_q <= 1'b0; blocked_q <= 1'b0;
      wdata_q <= '0;    fin_q <= '0; done_valid_q <= 1'b0; done_err_q <= 1'b0;
    end else begin
      done_valid_q <= 1'b0;
      done_err_q   <= 1'b0;
      if (ev_atomic_err) begin
        done_valid_q <= 1'b1;
        done_err_q   <= 1'b1;
      end
      if (ev_start) begin
        st_q    <= ST_ISSUE;
        addr_q  <= req_addr;   bnd_q <= pl_bnd;
        s0_q    <= pl_s0;      s1_q  <= pl_s1;
        split_q <= pl_split;   wr_q  <= req_write;
        wdata_q <= req_wdata;  half_q <= 1'b0; fin_q <= '0;
      end
      if (ev_taken) st_q <= ST_WAIT;
      if (ev_refused) blocked_q <= 1'b1;
      else if (ev_retry_clear) blocked_q <= 1'b0;
      if (ev_resp) begin
        fin_q <= fin_q + 2'd1;
        if (ev_final) begin
          st_q         <= ST_IDLE;
          done_valid_q <= 1'b1;
        end else begin
          half_q <= 1'b1;
          st_q   <= ST_ISSUE;
        end
      end
    end
  end

  // R2: every sub-request stays inside one line
  p_half_in_line_r2: assert property (@(posedge clk) disable iff (!rst_n)
    c_req_valid |-> line_of(c_req_addr) ==
                    line_of(c_req_addr + AW'(c_req_size) - AW'(1)));
  // R6: a refused sub-request silences the port next cycle
  p_refusal_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (c_req_valid && !c_req_accept) |=> (!c_req_valid && !req_ready));
  // R7: retry re-presents the same sub-request
  p_retry_reissue_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (blocked_q && c_retry) |=> (c_req_valid && $stable(c_req_addr) &&
                                $stable(c_req_size) && $stable(c_req_be)));
  // R5: a good completion follows a sampled response
  p_done_after_resp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && !done_error) |-> $past(c_resp_valid));
  // R8: an error completion follows an accepted write, nothing issued
  p_err_from_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_error |-> (done_valid && !c_req_valid && $past(req_valid && req_write)));
  // R2: no sub-request is presented while one is outstanding
  p_single_outstanding_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT) |-> !c_req_valid);
endmodule

// File: tb/tb_line_split_unit.sv
module tb_line_split_unit;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32, LINE = 64, MB = 8, DW = 64, SZW = 4;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, req_atomic = 0;
  logic [AW-1:0] req_addr = 0;
  logic [SZW-1:0] req_size = 0;
  logic [DW-1:0] req_wdata = 0;
  logic c_req_accept = 1, c_retry = 0, c_resp_valid = 0;
  logic [DW-1:0] c_resp_data = 0;
  logic req_ready, c_req_valid, c_req_write, done_valid, done_error;
  logic [AW-1:0] c_req_addr;
  logic [SZW-1:0] c_req_size;
  logic [DW-1:0] c_req_wdata, done_data;
  logic [MB-1:0] c_req_be;

  line_split_unit #(.AW(AW), .LINE_BYTES(LINE), .MAX_BYTES(MB)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  // model expectations
  bit e_rdy, e_cv, e_cwr, e_dv, e_err;
  logic [AW-1:0] e_caddr;
  int e_csz;
  logic [DW-1:0] e_cwd, e_data;
  logic [MB-1:0] e_cbe;

  task automatic chk(input string tag, input string sig, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, sig, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic look(input string tag);
    #1;
    chk(tag, "req_ready", 64'(req_ready), 64'(e_rdy));
    chk(tag, "c_req_valid", 64'(c_req_valid), 64'(e_cv));
    chk(tag, "done_valid", 64'(done_valid), 64'(e_dv));
    if (e_cv) begin
      chk(tag, "c_req_addr", 64'(c_req_addr), 64'(e_caddr));
      chk(tag, "c_req_size", 64'(c_req_size), 64'(e_csz));
      chk(tag, "c_req_write", 64'(c_req_write), 64'(e_cwr));
      chk(tag, "c_req_wdata", c_req_wdata, e_cwd);
      chk(tag, "c_req_be", 64'(c_req_be), 64'(e_cbe));
    end
    if (e_dv) begin
      chk(tag, "done_error", 64'(done_error), 64'(e_err));
      chk(tag, "done_data", done_data, e_data);
    end
  endtask

  // refuse_h: half to refuse once (-1 none); poke: drive req_valid while busy
  task automatic access(input string tag, input int a, input int sz, input bit wr,
                        input bit at, input logic [63:0] wd, input logic [63:0] r0,
                        input logic [63:0] r1, input int refuse_h, input bit poke);
    int bnd, s0, s1, nh;
    bit sp;
    logic [63:0] acc;
    bnd = ((a + sz - 1) / LINE) * LINE;            // R1
    sp  = bnd > a;
    s0  = sp ? bnd - a : sz;
    s1  = sp ? a + sz - bnd : 0;
    nh  = sp ? 2 : 1;
    acc = '0;
    req_valid = 1; req_addr = AW'(a); req_size = SZW'(sz);
    req_write = wr; req_atomic = at; req_wdata = wd;
    e_rdy = 1; e_cv = 0; e_dv = 0;
    look({tag, " R10 idle"});
    tick();
    req_valid = 0;
    if (sp && wr && at) begin                      // R8
      e_dv = 1; e_err = 1; e_data = '0; e_rdy = 1;
      look({tag, " R8 error"});
      tick(); e_dv = 0;
      look({tag, " R8 after"});
      return;
    end
    e_rdy = 0;
    for (int h = 0; h < nh; h++) begin
      int off = (h == 1) ? s0 : 0;
      int hs  = (h == 1) ? s1 : s0;
      e_cv = 1; e_caddr = AW'((h == 1) ? bnd : a); e_csz = hs; e_cwr = wr;
      e_cwd = '0; e_cbe = '0;
      if (wr) for (int j = 0; j < hs; j++) begin   // R3
        e_cwd[j*8 +: 8] = wd[(off + j)*8 +: 8];
        e_cbe[j] = 1'b1;
      end
      if (refuse_h == h) begin                     // R6 / R7
        c_req_accept = 0;
        look({tag, " R6 refused"});
        tick(); c_req_accept = 1; e_cv = 0;
        look({tag, " R6 blocked"});
        tick();
        look({tag, " R6 still blocked"});
        c_retry = 1;
        look({tag, " R7 retry"});
        tick(); c_retry = 0; e_cv = 1;
        look({tag, " R7 reissue"});
      end else begin
        look({tag, " R1 R2 issue"});
      end
      tick(); e_cv = 0;
      look({tag, " R2 wait"});
      if (poke) begin                              // R10
        req_valid = 1; req_addr = AW'(a) ^ 32'h1000; req_size = 1;
        look({tag, " R10 busy poke"});
        tick(); req_valid = 0;
        look({tag, " R10 ignored"});
      end else begin
        tick();
        look({tag, " R5 no early done"});
      end
      c_resp_valid = 1; c_resp_data = (h == 1) ? r1 : r0;
      look({tag, " R5 resp"});
      tick(); c_resp_valid = 0;
      if (!wr) for (int j = 0; j < hs; j++)        // R4
        acc[(off + j)*8 +: 8] = c_resp_data[j*8 +: 8];
    end
    e_dv = 1; e_err = 0; e_data = acc; e_rdy = 1; e_cv = 0;
    look({tag, " R4 R5 done"});
    tick(); e_dv = 0;
    look({tag, " R5 pulse end"});
  endtask

  initial begin
    e_rdy = 1; e_cv = 0; e_dv = 0; e_err = 0; e_csz = 0;
    e_caddr = '0; e_cwd = '0; e_cbe = '0; e_cwr = 0; e_data = '0;
    repeat (3) @(posedge clk);
    #1;
    look("R9 in reset");
    rst_n = 1;
    tick();
    look("R9 after reset");
    access("T1 plain read",      'h100, 4, 0, 0, '0, 64'hFFEE_DDCC_4433_2211, '0, -1, 0);
    access("T2 split read",      'h13D, 8, 0, 0, '0, 64'h9999_9999_9988_7766, 64'h7777_7755_4433_2211, -1, 0);
    access("T3 split write",     'h7E, 4, 1, 0, 64'h0807_0605_D4C3_B2A1, '0, '0, -1, 0);
    access("T4 ends at line R1", 'h38, 8, 0, 0, '0, 64'h0102_0304_0506_0708, '0, -1, 0);
    access("T5 starts line R1",  'h40, 8, 1, 0, 64'h1122_3344_5566_7788, '0, '0, -1, 0);
    access("T6 refuse 2nd",      'h3A, 8, 0, 0, '0, 64'hAAAA_6655_4433_2211, 64'hBBBB_BBBB_BB88_7766, 1, 0);
    access("T7 refuse 1st",      'h1F9, 8, 1, 0, 64'hF8F7_F6F5_F4F3_F2F1, '0, '0, 0, 0);
    access("T8 atomic split wr", 'h7C, 8, 1, 1, 64'h1234_5678_9ABC_DEF0, '0, '0, -1, 0);
    access("T9 atomic whole wr", 'h80, 8, 1, 1, 64'h0F0E_0D0C_0B0A_0908, '0, '0, -1, 0);
    access("T10 atomic split rd",'hBE, 4, 0, 1, '0, 64'h5555_5555_5555_BBAA, 64'h6666_6666_6666_DDCC, -1, 0);
    access("T11 busy poke",      'h17F, 2, 0, 0, '0, 64'hEEEE_EEEE_EEEE_EE5A, 64'hEEEE_EEEE_EEEE_EEA5, -1, 1);
    access("T12 byte write",     'h205, 1, 1, 0, 64'hFFFF_FFFF_FFFF_FF3C, '0, '0, -1, 1);
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      finished = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog R5 actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule